// File: doc/BRIEF.md
# Store Vulnerability Verification Filter

This block decides, just before a load commits, whether the value the load obtained can still be trusted or whether the load must run again. It keeps a direct-mapped table indexed by a slice of the address. Each entry holds the upper address bits as a tag and the sequence number of the youngest store to that slot that has completed to the data cache. Stores carry sequence numbers that only ever increase. Every store that completes to the cache writes its address and sequence number into the table. The block also keeps that number as the count of completed stores, because stores complete in order.

A load being verified presents three things: its address, the start of its vulnerability window, and the end of that window. The start is the sequence number of the store it forwarded from, or the completed-store count at the moment it read the cache. The end is the youngest store dispatched before the load. The verdict is one of three outcomes, each on its own valid/ready pair:

- **wait**: the window reaches past the stores completed so far.
- **safe**: the slot holds this address and no younger store has written it.
- **replay**: any other case. This includes an empty slot and a slot that holds a different address.

Re-executing the load and squashing the pipeline are not part of this block.

Top module: `svf_filter`

## Requirements
- R1: After reset every table entry is invalid, no outcome is valid and `ld_ready` is 1. A load checked before any store completes (window end 0) gets replay.
- R2: The slot is chosen by address bits [8:3] (`IDX_LO`=3, `IDX_W`=6). The tag is bits [31:9]. Bits [2:0] take no part in the decision.
- R3: A load whose slot is valid, whose tag matches, and whose window start is greater than or equal to the stored sequence number gets safe.
- R4: A load whose tag matches but whose window start is below the stored sequence number gets replay.
- R5: A load that maps to a valid slot holding a different tag gets replay.
- R6: A load whose window end is greater than the completed-store count gets wait, whatever the table holds. A store completing in the same cycle as the load is accepted counts as completed.
- R7: When a store completion and a load acceptance hit the same slot in the same cycle, the store's write is applied before the load's lookup.
- R8: A load is accepted on a cycle where `ld_valid` and `ld_ready` are both 1. Its outcome becomes valid after the second rising edge, counting the accepting edge as the first. Exactly one of the three outcome valids is raised. That outcome stays raised until its own ready is seen high. `ld_ready` stays 0 from acceptance until the outcome is taken.
- R9: A store that completes after a load has been accepted does not change that load's verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | A store completes to the cache this cycle |
| st_addr | input | ADDR_W | Address of the completing store |
| st_ssn | input | SSN_W | Sequence number of the completing store |
| ld_valid | input | 1 | A load requests verification |
| ld_ready | output | 1 | Filter can accept a load |
| ld_addr | input | ADDR_W | Load address |
| ld_start_ssn | input | SSN_W | Start of the load's vulnerability window |
| ld_end_ssn | input | SSN_W | Youngest store dispatched before the load |
| wait_valid | output | 1 | Outcome: window not yet complete |
| wait_ready | input | 1 | Wait outcome taken |
| safe_valid | output | 1 | Outcome: value proven correct |
| safe_ready | input | 1 | Safe outcome taken |
| replay_valid | output | 1 | Outcome: load must re-execute |
| replay_ready | input | 1 | Replay outcome taken |

## Verification
The bench runs two sweeps over all 64 slots.

- **Empty table:** a load to every slot before any store separates an invalid entry from a real hit.
- **Filled table:** after a store fills each slot, every slot is probed three ways. A window start equal to the stored number must give safe; one below it must give replay; a different tag must give replay. This separates the sequence comparison from the tag comparison, and the probes vary the low address bits.

Targeted patterns then cover further cases:

- A window end one past the completed count gives wait.
- A store in the same cycle as the load, to the same slot, must be seen by that load.
- A store one cycle after acceptance must not be seen.
- An outcome held with its ready low must persist while new loads stay blocked.

// File: rtl/svf_pkg.sv
package svf_pkg;
  typedef enum logic [1:0] {
    V_WAIT   = 2'd0,
    V_SAFE   = 2'd1,
    V_REPLAY = 2'd2
  } verdict_e;
endpackage

// File: rtl/svf_table.sv
module svf_table #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 23,
  parameter int SSN_W = 16
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [SSN_W-1:0] wr_ssn,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic [SSN_W-1:0] rd_ssn
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = TAG_W + SSN_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;

  // plain read-first array so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_ssn};
    if (rd_en) rd_q <= mem[rd_idx];
  end

  assign rd_tag = rd_q[ENT_W-1 -: TAG_W];
  assign rd_ssn = rd_q[SSN_W-1:0];
endmodule

// File: rtl/svf_valid_bits.sv
module svf_valid_bits #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
      rd_bit <= 1'b0;
    end else begin
      if (set_en) bits_q[set_idx] <= 1'b1;
      if (rd_en)  rd_bit <= bits_q[rd_idx] | (set_en && set_idx == rd_idx);
    end
  end
endmodule

// File: rtl/svf_judge.sv
module svf_judge
  import svf_pkg::*;
#(
  parameter int TAG_W = 23,
  parameter int SSN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_wait,
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [SSN_W-1:0] ent_ssn,
  input  logic [TAG_W-1:0] want_tag,
  input  logic [SSN_W-1:0] start_ssn,
  input  logic             wait_ready,
  input  logic             safe_ready,
  input  logic             replay_ready,
  output logic             wait_valid,
  output logic             safe_valid,
  output logic             replay_valid
);
  verdict_e verdict;

  always_comb begin
    if (in_wait)
      verdict = V_WAIT;
    else if (ent_valid && ent_tag == want_tag && ent_ssn <= start_ssn)
      verdict = V_SAFE;
    else
      verdict = V_REPLAY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_valid   <= 1'b0;
      safe_valid   <= 1'b0;
      replay_valid <= 1'b0;
    end else if (in_vld) begin
      wait_valid   <= (verdict == V_WAIT);
      safe_valid   <= (verdict == V_SAFE);
      replay_valid <= (verdict == V_REPLAY);
    end else begin
      if (wait_ready)   wait_valid   <= 1'b0;
      if (safe_ready)   safe_valid   <= 1'b0;
      if (replay_ready) replay_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/svf_filter.sv
module svf_filter #(
  parameter int ADDR_W = 32,
  parameter int SSN_W  = 16,
  parameter int IDX_LO = 3,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SSN_W-1:0]  st_ssn,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SSN_W-1:0]  ld_start_ssn,
  input  logic [SSN_W-1:0]  ld_end_ssn,
  output logic              wait_valid,
  input  logic              wait_ready,
  output logic              safe_valid,
  input  logic              safe_ready,
  output logic              replay_valid,
  input  logic              replay_ready
);
  localparam int TAG_W = ADDR_W - IDX_LO - IDX_W;

  logic [IDX_W-1:0] st_idx, ld_idx;
  logic [TAG_W-1:0] st_tag, ld_tag;
  logic             ld_fire;
  logic [SSN_W-1:0] done_q, done_now;

  assign st_idx  = st_addr[IDX_LO +: IDX_W];
  assign ld_idx  = ld_addr[IDX_LO +: IDX_W];
  assign st_tag  = st_addr[ADDR_W-1 -: TAG_W];
  assign ld_tag  = ld_addr[ADDR_W-1 -: TAG_W];
  assign ld_fire = ld_valid && ld_ready;

  // stores complete in order: the last completed number bounds all windows
  always_ff @(posedge clk) begin
    if (rst)           done_q <= '0;
    else if (st_valid) done_q <= st_ssn;
  end
  assign done_now = st_valid ? st_ssn : done_q;

  // lookup stage registers
  logic             a_vld, a_wait, a_byp, a_ent_vld;
  logic [TAG_W-1:0] a_tag, a_byp_tag, rd_tag;
  logic [SSN_W-1:0] a_start, a_byp_ssn, rd_ssn;

  always_ff @(posedge clk) begin
    if (rst) a_vld <= 1'b0;
    else     a_vld <= ld_fire;
  end

  always_ff @(posedge clk) begin
    if (ld_fire) begin
      a_wait    <= ld_end_ssn > done_now;
      a_tag     <= ld_tag;
      a_start   <= ld_start_ssn;
      a_byp     <= st_valid && st_idx == ld_idx;
      a_byp_tag <= st_tag;
      a_byp_ssn <= st_ssn;
    end
  end

  svf_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .SSN_W(SSN_W)) u_table (
    .clk    (clk),
    .wr_en  (st_valid),
    .wr_idx (st_idx),
    .wr_tag (st_tag),
    .wr_ssn (st_ssn),
    .rd_en  (ld_fire),
    .rd_idx (ld_idx),
    .rd_tag (rd_tag),
    .rd_ssn (rd_ssn)
  );

  svf_valid_bits #(.IDX_W(IDX_W)) u_vbits (
    .clk     (clk),
    .rst     (rst),
    .set_en  (st_valid),
    .set_idx (st_idx),
    .rd_en   (ld_fire),
    .rd_idx  (ld_idx),
    .rd_bit  (a_ent_vld)
  );

  svf_judge #(.TAG_W(TAG_W), .SSN_W(SSN_W)) u_judge (
    .clk          (clk),
    .rst          (rst),
    .in_vld       (a_vld),
    .in_wait      (a_wait),
    .ent_valid    (a_ent_vld),
    .ent_tag      (a_byp ? a_byp_tag : rd_tag),
    .ent_ssn      (a_byp ? a_byp_ssn : rd_ssn),
    .want_tag     (a_tag),
    .start_ssn    (a_start),
    .wait_ready   (wait_ready),
    .safe_ready   (safe_ready),
    .replay_ready (replay_ready),
    .wait_valid   (wait_valid),
    .safe_valid   (safe_valid),
    .replay_valid (replay_valid)
  );

  assign ld_ready = !a_vld && !wait_valid && !safe_valid && !replay_valid;
endmodule

// File: rtl/svf_filter_chk.sv
module svf_filter_chk #(
  parameter int SSN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             st_valid,
  input logic [SSN_W-1:0] st_ssn,
  input logic             ld_valid,
  input logic             ld_ready,
  input logic [SSN_W-1:0] ld_end_ssn,
  input logic             wait_valid,
  input logic             wait_ready,
  input logic             safe_valid,
  input logic             safe_ready,
  input logic             replay_valid,
  input logic             replay_ready
);
  logic [SSN_W-1:0] seen_q;
  logic             any_out;

  always_ff @(posedge clk) begin
    if (rst)           seen_q <= '0;
    else if (st_valid) seen_q <= st_ssn;
  end
  assign any_out = wait_valid || safe_valid || replay_valid;

  // R8
  one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wait_valid, safe_valid, replay_valid}));

  // R8
  no_early_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready) |=> !any_out);

  // R8
  busy_blocks_load_chk: assert property (@(posedge clk) disable iff (rst)
    any_out |-> !ld_ready);

  // R8
  safe_held_chk: assert property (@(posedge clk) disable iff (rst)
    (safe_valid && !safe_ready) |=> safe_valid);

  // R8
  replay_held_chk: assert property (@(posedge clk) disable iff (rst)
    (replay_valid && !replay_ready) |=> replay_valid);

  // R8
  wait_held_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_valid && !wait_ready) |=> wait_valid);

  // R6
  open_window_waits_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready && ld_end_ssn > (st_valid ? st_ssn : seen_q))
      |=> ##1 wait_valid);
endmodule

bind svf_filter svf_filter_chk #(.SSN_W(SSN_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .st_valid     (st_valid),
  .st_ssn       (st_ssn),
  .ld_valid     (ld_valid),
  .ld_ready     (ld_ready),
  .ld_end_ssn   (ld_end_ssn),
  .wait_valid   (wait_valid),
  .wait_ready   (wait_ready),
  .safe_valid   (safe_valid),
  .safe_ready   (safe_ready),
  .replay_valid (replay_valid),
  .replay_ready (replay_ready)
);

// File: tb/tb_svf_filter.sv
`timescale 1ns/1ps
module tb_svf_filter;
  localparam int C_WAIT = 0, C_SAFE = 1, C_REPLAY = 2, C_NONE = 3, C_MULTI = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [15:0] st_ssn = '0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [31:0] ld_addr = '0;
  logic [15:0] ld_start_ssn = '0, ld_end_ssn = '0;
  logic        wait_valid, safe_valid, replay_valid;
  logic        wait_ready = 1'b1, safe_ready = 1'b1, replay_ready = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  svf_filter dut (.*);

  function automatic int code();
    int n = int'(wait_valid) + int'(safe_valid) + int'(replay_valid);
    if (n == 0) return C_NONE;
    if (n > 1)  return C_MULTI;
    if (wait_valid) return C_WAIT;
    if (safe_valid) return C_SAFE;
    return C_REPLAY;
  endfunction

  function automatic logic [31:0] mk(input int tag, input int idx, input int low);
    return {tag[22:0], idx[5:0], low[2:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_store(input logic [31:0] a, input logic [15:0] s);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_ssn = s;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  // drives one load (optionally with a same-cycle store), checks the verdict
  task automatic do_load(input logic [31:0] a, input logic [15:0] s, input logic [15:0] e,
                         input bit with_st, input logic [31:0] sa, input logic [15:0] ss,
                         input int exp, input string req);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_start_ssn = s; ld_end_ssn = e;
    if (with_st) begin st_valid = 1'b1; st_addr = sa; st_ssn = ss; end
    @(negedge clk);
    ld_valid = 1'b0; st_valid = 1'b0;
    if (code() != C_NONE) check(1'b0, "R8 latency", code(), C_NONE);
    @(negedge clk);
    check(code() == exp, req, code(), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(ld_ready == 1'b1, "R1 ld_ready", int'(ld_ready), 1);
    check(code() == C_NONE, "R1 no outcome", code(), C_NONE);
    // R1 every slot empty -> replay
    for (int i = 0; i < 64; i++)
      do_load(mk(5, i, 0), 16'd0, 16'd0, 1'b0, '0, '0, C_REPLAY, "R1 empty slot");

    // fill every slot: tag 5, ssn 10+i, varied low bits (R2)
    for (int i = 0; i < 64; i++)
      do_store(mk(5, i, i % 8), 16'(10 + i));

    for (int i = 0; i < 64; i++) begin
      do_load(mk(5, i, 7 - i % 8), 16'(10 + i), 16'd73, 1'b0, '0, '0, C_SAFE, "R3 R2 start equals stored");
      do_load(mk(5, i, 0), 16'(9 + i), 16'd73, 1'b0, '0, '0, C_REPLAY, "R4 start below stored");
      do_load(mk(6, i, 0), 16'd73, 16'd73, 1'b0, '0, '0, C_REPLAY, "R5 tag mismatch");
    end

    // R6 window end beyond completed count
    do_load(mk(5, 3, 0), 16'd73, 16'd74, 1'b0, '0, '0, C_WAIT, "R6 open window");
    // R6 + R7 same-cycle store counts as completed and is seen first
    do_load(mk(5, 0, 0), 16'd74, 16'd74, 1'b1, mk(5, 0, 4), 16'd74, C_SAFE, "R7 R6 same-cycle store");
    do_load(mk(5, 1, 0), 16'd11, 16'd75, 1'b1, mk(5, 1, 0), 16'd75, C_REPLAY, "R7 same-cycle newer store");

    // R9 store right after acceptance is not seen
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = mk(5, 2, 0); ld_start_ssn = 16'd75; ld_end_ssn = 16'd75;
    @(negedge clk);
    ld_valid = 1'b0;
    st_valid = 1'b1; st_addr = mk(5, 2, 0); st_ssn = 16'd76;
    @(negedge clk);
    st_valid = 1'b0;
    check(code() == C_SAFE, "R9 late store ignored", code(), C_SAFE);
    // and it is seen by the next load
    do_load(mk(5, 2, 0), 16'd75, 16'd76, 1'b0, '0, '0, C_REPLAY, "R9 later load sees store");

    // R8 hold while ready low
    safe_ready = 1'b0;
    do_load(mk(5, 2, 0), 16'd76, 16'd76, 1'b0, '0, '0, C_SAFE, "R8 outcome raised");
    ld_valid = 1'b1; ld_addr = mk(6, 5, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(code() == C_SAFE, "R8 held", code(), C_SAFE);
      check(ld_ready == 1'b0, "R8 blocked", int'(ld_ready), 0);
    end
    ld_valid = 1'b0;
    safe_ready = 1'b1;
    @(negedge clk);
    check(code() == C_NONE, "R8 released", code(), C_NONE);
    check(ld_ready == 1'b1, "R8 ready again", int'(ld_ready), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule